// File: doc/BRIEF.md
# Serial Flash Streaming Read Controller

This controller fetches data from an external SPI serial flash with a single-bit standard read and hands the bytes to a user interface one at a time. One request starts a flash transaction from a given start address. The transaction can then run on for any number of consecutive addresses, with no second command and no new address phase. The user keeps `rd_en` high to continue streaming and lowers it to end the transfer. Ending the transfer always yields exactly one more byte before the controller goes idle.

On the flash side the block drives the serial clock, an active-low chip select and the serial output, and it samples the serial input. The serial clock runs at the system clock rate while chip select is low, so after the command phase a new byte is assembled every eight system cycles. The byte output is a strobed stream with no back-pressure. The flash cannot be paused in the middle of a byte, so the consumer must capture `rd_data` in the single cycle in which `rd_valid` is high. A consumer that cannot keep up must lower `rd_en` to end the stream. A transfer that is already running cannot be stalled.

Top module: `sflash_stream_rd`

## Requirements
- R1: An asynchronous active-high reset takes effect at once. During reset `busy` and `rd_valid` are 0, `cs_n` is 1, `sck` is low and `rd_data` is 0.
- R2: A request is accepted on a rising clock edge only if `rd_req` and `rd_en` are both 1 and the block is idle, and `busy` is 1 from the following cycle. If `rd_req` is 1 while `rd_en` is 0, no transfer starts: `busy` stays 0 and `cs_n` stays 1.
- R3: After acceptance `cs_n` goes low and `mosi` carries 32 bits, most significant first, one bit per `sck` period: first the opcode 0x03, then the 24-bit start address. `mosi` changes on the falling edge of `sck`, and the flash samples it on the rising edge.
- R4: Data bits are sampled from `miso` on the rising edge of `sck`, most significant bit first. The first byte appears on `rd_data` with `rd_valid` exactly 40 cycles after the accepting edge.
- R5: `rd_valid` is high for exactly one cycle per byte. While `rd_en` stays high, the next byte's strobe follows the previous one after exactly 8 cycles.
- R6: `rd_addr` gives the flash address of the byte on `rd_data` during its strobe. It increases by one for each byte and wraps from 0xFFFFFF to 0x000000.
- R7: If `rd_en` is 0 at any edge after the strobe of byte n, the transfer ends with byte n+1. `busy` falls one cycle after that last strobe, and `cs_n` is already 1 by then.
- R8: If `rd_en` is high only in the accepting cycle, or falls at any time before the first strobe, exactly one byte is delivered.
- R9: Once a transfer has ended, `rd_data` keeps the last byte, and `rd_valid` stays 0, until the next strobe or a reset.
- R10: A request made while `busy` is 1 is ignored, and the running transfer's address sequence is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also the serial clock source |
| rst | input | 1 | Asynchronous active-high reset |
| rd_req | input | 1 | Read request, taken on a rising edge when idle |
| rd_en | input | 1 | Enable; hold high to keep streaming, lower to finish |
| start_addr | input | 24 | Flash start address, stable when rd_req is raised |
| busy | output | 1 | High from acceptance until one cycle after the last strobe |
| rd_data | output | 8 | Most recent byte read |
| rd_valid | output | 1 | One-cycle strobe marking a new byte on rd_data |
| rd_addr | output | 24 | Flash address of the byte on rd_data |
| sck | output | 1 | Serial clock to flash, idle low |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial command and address to flash |
| miso | input | 1 | Serial data from flash |

## Verification
The bound checker watches four things on every cycle: `rd_valid` never lasts two cycles, strobes within a transfer are exactly 8 cycles apart with addresses rising by one, chip select is high and no strobe occurs whenever `busy` is low, and `rd_data` changes only with a strobe. Other properties can only be shown by the bench's scenarios, using a flash model and a scoreboard: that the opcode and address bits really arrive in order, the 40-cycle first-byte latency, the exact byte count for each way of lowering `rd_en` (including the single-byte cases), address wrap at the top of the space, a request ignored mid-stream, and the data held after a transfer ends.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CMD  = 2'd1,
    ST_DATA = 2'd2,
    ST_DONE = 2'd3
  } sfr_state_e;
endpackage

// File: rtl/sfr_seq.sv
// Transfer sequencer: command phase, byte phases and end-of-stream decision.
module sfr_seq
  import sfr_pkg::*;
#(
  parameter int CMD_W  = 32,
  parameter int DATA_W = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rd_req,
  input  logic       rd_en,
  output sfr_state_e state,
  output logic       accept,
  output logic       byte_done,
  output logic       busy
);
  localparam int CW = $clog2(CMD_W);

  logic [CW-1:0] cnt;
  logic          stop_q;
  logic          stop_now;

  assign accept    = (state == ST_IDLE) && rd_req && rd_en;
  assign byte_done = (state == ST_DATA) && (cnt == CW'(DATA_W - 1));
  assign stop_now  = stop_q || !rd_en;
  assign busy      = (state != ST_IDLE);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      stop_q <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            state  <= ST_CMD;
            cnt    <= '0;
            stop_q <= 1'b0;
          end
        end
        ST_CMD: begin
          if (!rd_en) stop_q <= 1'b1;
          if (cnt == CW'(CMD_W - 1)) begin
            state <= ST_DATA;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_DATA: begin
          if (!rd_en) stop_q <= 1'b1;
          if (byte_done) begin
            cnt <= '0;
            if (stop_now) begin
              state  <= ST_DONE;
              stop_q <= 1'b0;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sfr_cmd_tx.sv
// Command/address shift register; MSB presented first.
module sfr_cmd_tx #(
  parameter int          ADDR_W    = 24,
  parameter int          CMD_W     = 32,
  parameter logic [7:0]  RD_OPCODE = 8'h03
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              shift,
  input  logic [ADDR_W-1:0] start_addr,
  output logic              cmd_bit
);
  logic [CMD_W-1:0] shreg;

  always_ff @(posedge clk or posedge rst) begin
    if (rst)        shreg <= '0;
    else if (load)  shreg <= {RD_OPCODE, start_addr};
    else if (shift) shreg <= {shreg[CMD_W-2:0], 1'b0};
  end

  assign cmd_bit = shreg[CMD_W-1];
endmodule

// File: rtl/sfr_pins.sv
// Flash pin drivers: falling-edge registers keep the gated clock glitch free
// and launch serial output on the falling edge of the serial clock.
module sfr_pins
  import sfr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  sfr_state_e state,
  input  logic       cmd_bit,
  output logic       sck,
  output logic       cs_n,
  output logic       mosi
);
  logic active;
  logic gate_q;

  assign active = (state == ST_CMD) || (state == ST_DATA);

  always_ff @(negedge clk or posedge rst) begin
    if (rst) begin
      gate_q <= 1'b0;
      cs_n   <= 1'b1;
      mosi   <= 1'b0;
    end else begin
      gate_q <= active;
      cs_n   <= !active;
      mosi   <= (state == ST_CMD) ? cmd_bit : 1'b0;
    end
  end

  assign sck = clk & gate_q;
endmodule

// File: rtl/sfr_rx.sv
// Byte assembly, output register and address tracking.
module sfr_rx #(
  parameter int ADDR_W    = 24,
  parameter int DATA_W    = 8,
  parameter bit SHOW_ADDR = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              sample,
  input  logic              byte_done,
  input  logic              miso,
  input  logic [ADDR_W-1:0] start_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic [ADDR_W-1:0] rd_addr
);
  logic [DATA_W-1:0] shin;
  logic [ADDR_W-1:0] addr_cur;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      shin     <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      if (sample) shin <= {shin[DATA_W-2:0], miso};
      if (byte_done) begin
        rd_data  <= {shin[DATA_W-2:0], miso};
        rd_valid <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst)            addr_cur <= '0;
    else if (load)      addr_cur <= start_addr;
    else if (byte_done) addr_cur <= addr_cur + 1'b1;
  end

  generate
    if (SHOW_ADDR) begin : g_addr
      always_ff @(posedge clk or posedge rst) begin
        if (rst)            rd_addr <= '0;
        else if (byte_done) rd_addr <= addr_cur;
      end
    end else begin : g_noaddr
      assign rd_addr = '0;
    end
  endgenerate
endmodule

// File: rtl/sflash_stream_rd.sv
module sflash_stream_rd
  import sfr_pkg::*;
#(
  parameter int         ADDR_W    = 24,
  parameter int         DATA_W    = 8,
  parameter logic [7:0] RD_OPCODE = 8'h03,
  parameter bit         SHOW_ADDR = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_req,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] start_addr,
  output logic              busy,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              sck,
  output logic              cs_n,
  output logic              mosi,
  input  logic              miso
);
  localparam int CMD_W = 8 + ADDR_W;

  sfr_state_e state;
  logic       accept;
  logic       byte_done;
  logic       cmd_bit;

  sfr_seq #(.CMD_W(CMD_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst(rst), .rd_req(rd_req), .rd_en(rd_en),
    .state(state), .accept(accept), .byte_done(byte_done), .busy(busy)
  );

  sfr_cmd_tx #(.ADDR_W(ADDR_W), .CMD_W(CMD_W), .RD_OPCODE(RD_OPCODE)) u_cmd (
    .clk(clk), .rst(rst), .load(accept), .shift(state == ST_CMD),
    .start_addr(start_addr), .cmd_bit(cmd_bit)
  );

  sfr_pins u_pins (
    .clk(clk), .rst(rst), .state(state), .cmd_bit(cmd_bit),
    .sck(sck), .cs_n(cs_n), .mosi(mosi)
  );

  sfr_rx #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SHOW_ADDR(SHOW_ADDR)) u_rx (
    .clk(clk), .rst(rst), .load(accept), .sample(state == ST_DATA),
    .byte_done(byte_done), .miso(miso), .start_addr(start_addr),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_addr(rd_addr)
  );
endmodule

// File: rtl/sfr_chk.sv
module sfr_chk #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              cs_n
);
  logic              have_prev;
  logic [ADDR_W-1:0] prev_addr;
  logic [15:0]       gap;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      have_prev <= 1'b0;
      prev_addr <= '0;
      gap       <= '0;
    end else if (!busy) begin
      have_prev <= 1'b0;
      gap       <= '0;
    end else if (rd_valid) begin
      have_prev <= 1'b1;
      prev_addr <= rd_addr;
      gap       <= 16'd1;
    end else if (gap != 16'hFFFF) begin
      gap <= gap + 16'd1;
    end
  end

  // R5
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);

  // R5
  valid_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && have_prev) |-> (gap == 16'(DATA_W)));

  // R6
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && have_prev) |-> (rd_addr == prev_addr + 1'b1));

  // R7
  idle_deselect_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (cs_n && !rd_valid));

  // R9
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_valid |-> $stable(rd_data));
endmodule

bind sflash_stream_rd sfr_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .rd_valid(rd_valid),
  .rd_data(rd_data), .rd_addr(rd_addr), .cs_n(cs_n)
);

// File: tb/tb_sflash_stream_rd.sv
module tb_sflash_stream_rd;
  localparam int AW = 24;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          rd_req = 1'b0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic          miso = 1'b0;
  logic          busy, rd_valid, sck, cs_n, mosi;
  logic [DW-1:0] rd_data;
  logic [AW-1:0] rd_addr;

  sflash_stream_rd dut (
    .clk(clk), .rst(rst), .rd_req(rd_req), .rd_en(rd_en),
    .start_addr(start_addr), .busy(busy), .rd_data(rd_data),
    .rd_valid(rd_valid), .rd_addr(rd_addr), .sck(sck), .cs_n(cs_n),
    .mosi(mosi), .miso(miso)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  always @(posedge clk) cyc++;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] mem_byte(input logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
  endfunction

  // Flash model
  int            fbits = 0;
  logic [31:0]   fcmd = '0;
  logic [AW-1:0] faddr = '0;
  logic [AW-1:0] drv_addr = '0;

  always @(negedge cs_n) begin
    fbits = 0;
    fcmd  = '0;
  end

  always @(posedge sck) begin
    if (!cs_n) begin
      if (fbits < 32) fcmd = {fcmd[30:0], mosi};
      fbits++;
      if (fbits == 32) begin
        faddr = fcmd[23:0];
        check(fcmd[31:24] == 8'h03, "R3", "opcode", 32'(fcmd[31:24]), 32'h03);
        check(fcmd[23:0] == drv_addr, "R3", "address bits", 32'(fcmd[23:0]), 32'(drv_addr));
      end
    end
  end

  always @(negedge sck) begin
    if (!cs_n && fbits >= 32) begin
      automatic int idx = fbits - 32;
      automatic logic [7:0] b = mem_byte(faddr + AW'(idx / 8));
      miso = b[7 - (idx % 8)];
    end
  end

  // Scoreboard
  logic [31:0] exp_q[$];
  int nvalid = 0;
  int accept_cyc = 0;
  int last_valid_cyc = 0;
  bit prev_v = 1'b0;
  logic [DW-1:0] last_exp = '0;

  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      check(!prev_v, "R5", "strobe width", 32'(prev_v), 32'd0);
      if (nvalid == 0)
        check(cyc - accept_cyc == 40, "R4", "first byte latency", 32'(cyc - accept_cyc), 32'd40);
      else
        check(cyc - last_valid_cyc == 8, "R5", "byte spacing", 32'(cyc - last_valid_cyc), 32'd8);
      if (exp_q.size() == 0) begin
        check(1'b0, "R7", "unexpected byte", 32'(rd_addr), 32'd0);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        check(rd_data == e[7:0], "R4", "data", 32'(rd_data), 32'(e[7:0]));
        check(rd_addr == e[31:8], "R6", "address", 32'(rd_addr), 32'(e[31:8]));
      end
      last_valid_cyc = cyc;
      nvalid++;
    end
    prev_v = !rst && rd_valid;
  end

  // mode 0: rd_en only in accept cycle; 1: drop mid-command; 2: normal
  task automatic do_read(input logic [AW-1:0] addr, input int n,
                         input int mode, input bit poke);
    for (int k = 0; k < n; k++) begin
      automatic logic [AW-1:0] a = addr + AW'(k);
      exp_q.push_back({a, mem_byte(a)});
      last_exp = mem_byte(a);
    end
    drv_addr = addr;
    nvalid = 0;
    @(negedge clk);
    start_addr = addr;
    rd_req = 1'b1;
    rd_en  = 1'b1;
    @(posedge clk);
    @(negedge clk);
    accept_cyc = cyc;
    rd_req = 1'b0;
    check(busy == 1'b1, "R2", "busy after accept", 32'(busy), 32'd1);
    if (mode == 0) begin
      rd_en = 1'b0;
    end else if (mode == 1) begin
      repeat (12) @(negedge clk);
      rd_en = 1'b0;
    end else begin
      if (poke) begin
        while (nvalid < 1) @(negedge clk);
        start_addr = ~addr;
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        check(busy == 1'b1, "R10", "still busy after ignored request", 32'(busy), 32'd1);
      end
      while (nvalid < n - 1) @(negedge clk);
      rd_en = 1'b0;
    end
    while (busy) @(negedge clk);
    check(nvalid == n, (mode == 2) ? "R7" : "R8", "byte count", 32'(nvalid), 32'(n));
    check(cyc - last_valid_cyc == 1, "R7", "busy fall after last strobe",
          32'(cyc - last_valid_cyc), 32'd1);
    check(cs_n == 1'b1, "R7", "deselected at end", 32'(cs_n), 32'd1);
    check(exp_q.size() == 0, "R7", "leftover expected bytes", 32'(exp_q.size()), 32'd0);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "R5", "watchdog", 32'd1, 32'd0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 0 && rd_valid == 0, "R1", "busy/valid in reset", {busy, rd_valid}, 32'd0);
    check(cs_n == 1 && sck == 0, "R1", "pins in reset", {cs_n, sck}, 32'h2);
    check(rd_data == 0, "R1", "data in reset", 32'(rd_data), 32'd0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R2: request without enable
    start_addr = 24'h000777;
    rd_req = 1'b1;
    rd_en  = 1'b0;
    repeat (4) @(negedge clk);
    rd_req = 1'b0;
    check(busy == 1'b0, "R2", "no start without rd_en", 32'(busy), 32'd0);
    check(cs_n == 1'b1, "R2", "cs_n idle without rd_en", 32'(cs_n), 32'd1);

    do_read(24'h012345, 1, 0, 1'b0);   // R8 one-cycle enable
    do_read(24'h00ABCD, 5, 2, 1'b0);   // R5 R6 R7 stream
    do_read(24'h123400, 1, 1, 1'b0);   // R8 drop during command
    do_read(24'hFFFFFE, 4, 2, 1'b1);   // R6 wrap, R10 ignored request
    do_read(24'h000100, 2, 2, 1'b0);   // R7 shortest stream

    // R9: data held after end
    repeat (10) @(negedge clk);
    check(rd_data == last_exp, "R9", "held data", 32'(rd_data), 32'(last_exp));
    check(rd_valid == 1'b0, "R9", "no strobe while idle", 32'(rd_valid), 32'd0);

    // R1: asynchronous reset in the middle of a stream
    drv_addr = 24'h00F000;
    @(negedge clk);
    start_addr = 24'h00F000;
    rd_req = 1'b1;
    rd_en  = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
    repeat (20) @(negedge clk);
    #1 rst = 1'b1;
    #1;
    check(busy == 1'b0, "R1", "busy cleared by async reset", 32'(busy), 32'd0);
    check(cs_n == 1'b1, "R1", "cs_n raised by async reset", 32'(cs_n), 32'd1);
    rd_en = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(rd_data == 0 && rd_valid == 0, "R1", "outputs after reset", {rd_data, rd_valid}, 32'd0);
    finish_run();
  end
endmodule